// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Controller

This block sits beside the storage of a dual-clock FIFO. It holds two threshold registers, an empty-side offset and a full-side offset, and uses them to drive two active-low warning flags. The almost-empty flag is driven by the read side's word count and is registered on the read clock. The almost-full flag is driven by the write side's word count and is registered on the write clock.

A configuration pin is sampled during master reset. It fixes the programming method for both offsets until the next master reset, and it loads one of two default offset pairs. In parallel mode the offsets are written from a data bus. In serial mode they are shifted in one bit per write clock. In either mode both offsets can be read back on a parallel output.

Partial reset restarts the programming and readback sequences and forces the flags to their idle values. It keeps both offsets and the chosen method. During a retransmit setup the almost-empty flag is frozen for one read-clock edge, so the FIFO can rewind its read pointer before the flag is updated.

Top module: `almost_flag_ctrl`

## Requirements
- R1: While mst_rst_i is high, a low cfg_serial_i selects parallel mode and loads 127 into both offsets. A high cfg_serial_i selects serial mode and loads 1023 into both offsets.
- R2: The method chosen at master reset cannot be changed by anything else. In parallel mode, serial shifting leaves both offsets unchanged. In serial mode, parallel writes leave both offsets unchanged.
- R3: off_q_o shows the empty-side offset after any reset. Each read-clock edge with prog_i and rd_en_i both high switches the view to the other offset. This works in both modes.
- R4: In parallel mode, the first write-clock edge with prog_i and wr_en_i high stores off_d_i into the empty-side offset. The second such edge stores it into the full-side offset, and the third goes back to the empty side.
- R5: In serial mode, each write-clock edge with ser_en_i high stores ser_d_i into the next bit. The order is empty-side bits 0 to AW-1, then full-side bits 0 to AW-1, then the sequence starts again.
- R6: Partial reset keeps both offsets and the programming method. It returns the parallel-write, serial-bit and readback sequences to their first position.
- R7: Unless held, almost_empty_n_o is low one read-clock edge after rd_cnt_i is less than or equal to the empty-side offset, and high otherwise.
- R8: almost_full_n_o is low one write-clock edge after 2^AW minus wr_cnt_i is less than or equal to the full-side offset, and high otherwise.
- R9: A read-clock edge that samples retx_i high leaves almost_empty_n_o unchanged. After a one-cycle retransmit setup, the flag takes its new value on the second read-clock edge.
- R10: On a clock edge that samples either reset high, almost_empty_n_o is driven low and almost_full_n_o is driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| mst_rst_i | input | 1 | Master reset, synchronous, active high |
| part_rst_i | input | 1 | Partial reset, synchronous, active high |
| cfg_serial_i | input | 1 | Method and default select, sampled during master reset |
| prog_i | input | 1 | Qualifies wr_en_i and rd_en_i as offset accesses |
| wr_en_i | input | 1 | Parallel offset write strobe (write clock) |
| rd_en_i | input | 1 | Parallel offset readback advance (read clock) |
| ser_en_i | input | 1 | Serial shift enable (write clock) |
| ser_d_i | input | 1 | Serial offset bit |
| off_d_i | input | AW | Parallel offset data in |
| off_q_o | output | AW | Offset readback |
| wr_cnt_i | input | AW+1 | Stored-word count as seen by the write side |
| rd_cnt_i | input | AW+1 | Stored-word count as seen by the read side |
| retx_i | input | 1 | Retransmit setup, holds the almost-empty flag |
| almost_empty_n_o | output | 1 | Almost-empty flag, active low |
| almost_full_n_o | output | 1 | Almost-full flag, active low |

## Verification
The assertions check several rules on every clock edge: the defaults loaded during master reset, that the programming method never changes, and that each method's offsets stay still when only the other method's strobes are active. They also check both flag equations against the sampled counts, the freeze during retransmit, and the flag values forced by reset. Some behaviours can only be shown by the bench's scenarios. These are the order in which parallel writes and serial bits fill the two registers, the wrap back to the empty-side offset, the readback order, and that partial reset restarts those sequences while keeping the stored offsets. The bench also sweeps every count from 0 to 2^AW at both threshold extremes.

// File: rtl/afo_pkg.sv
package afo_pkg;

  typedef enum logic {
    PROG_PARALLEL = 1'b0,
    PROG_SERIAL   = 1'b1
  } prog_mode_e;

  // level at or below the threshold means the warning is active
  function automatic logic flag_hit(input int unsigned level, input int unsigned thresh);
    return level <= thresh;
  endfunction

  // words still free when cnt words are stored in a depth-word buffer
  function automatic int unsigned free_space(input int unsigned depth, input int unsigned cnt);
    return depth - cnt;
  endfunction

endpackage

// File: rtl/afo_offset_bank.sv
module afo_offset_bank
  import afo_pkg::*;
#(
  parameter int AW      = 14,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic          wclk_i,
  input  logic          mst_rst_i,
  input  logic          part_rst_i,
  input  logic          cfg_serial_i,
  input  logic          prog_i,
  input  logic          wr_en_i,
  input  logic          ser_en_i,
  input  logic          ser_d_i,
  input  logic [AW-1:0] off_d_i,
  output prog_mode_e    mode_o,
  output logic [AW-1:0] off_empty_o,
  output logic [AW-1:0] off_full_o
);
  localparam int NBITS = 2 * AW;
  localparam int SW    = $clog2(NBITS);
  localparam int IW    = $clog2(AW);
  localparam logic [AW-1:0] DEF_P = AW'(DEF_PAR);
  localparam logic [AW-1:0] DEF_S = AW'(DEF_SER);
  localparam logic [SW-1:0] LAST  = SW'(NBITS - 1);
  localparam logic [SW-1:0] HALF  = SW'(AW);

  logic          par_sel;   // 0: empty side next, 1: full side next
  logic [SW-1:0] bit_ptr;
  logic [SW-1:0] bit_off;
  logic [IW-1:0] bit_idx;
  logic          bit_hi;
  logic          par_wr;
  logic          ser_wr;

  assign par_wr = (mode_o == PROG_PARALLEL) && prog_i && wr_en_i;
  assign ser_wr = (mode_o == PROG_SERIAL) && ser_en_i;

  always_comb begin
    bit_hi  = (bit_ptr >= HALF);
    bit_off = bit_hi ? (bit_ptr - HALF) : bit_ptr;
    bit_idx = bit_off[IW-1:0];
  end

  always_ff @(posedge wclk_i) begin
    if (mst_rst_i) begin
      mode_o      <= cfg_serial_i ? PROG_SERIAL : PROG_PARALLEL;
      off_empty_o <= cfg_serial_i ? DEF_S : DEF_P;
      off_full_o  <= cfg_serial_i ? DEF_S : DEF_P;
      par_sel     <= 1'b0;
      bit_ptr     <= '0;
    end else if (part_rst_i) begin
      par_sel <= 1'b0;
      bit_ptr <= '0;
    end else begin
      if (par_wr) begin
        if (!par_sel) off_empty_o <= off_d_i;
        else          off_full_o  <= off_d_i;
        par_sel <= ~par_sel;
      end
      if (ser_wr) begin
        if (!bit_hi) off_empty_o[bit_idx] <= ser_d_i;
        else         off_full_o[bit_idx]  <= ser_d_i;
        bit_ptr <= (bit_ptr == LAST) ? '0 : bit_ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/afo_flag_cell.sv
module afo_flag_cell
  import afo_pkg::*;
#(
  parameter int   AW        = 14,
  parameter bit   FULL_SIDE = 1'b0,
  parameter logic RST_VAL   = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          hold_i,
  input  logic [AW:0]   cnt_i,
  input  logic [AW-1:0] off_i,
  output logic          hit_o,
  output logic          flag_n_o
);
  localparam int unsigned DEPTH = 1 << AW;

  int unsigned level;

  generate
    if (FULL_SIDE) begin : g_free
      always_comb level = free_space(DEPTH, 32'(cnt_i));
    end else begin : g_used
      always_comb level = 32'(cnt_i);
    end
  endgenerate

  assign hit_o = flag_hit(level, 32'(off_i));

  always_ff @(posedge clk_i) begin
    if (rst_i)        flag_n_o <= RST_VAL;
    else if (!hold_i) flag_n_o <= ~hit_o;
  end

endmodule

// File: rtl/almost_flag_ctrl.sv
module almost_flag_ctrl
  import afo_pkg::*;
#(
  parameter int AW      = 14,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          mst_rst_i,
  input  logic          part_rst_i,
  input  logic          cfg_serial_i,
  input  logic          prog_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic          ser_en_i,
  input  logic          ser_d_i,
  input  logic [AW-1:0] off_d_i,
  output logic [AW-1:0] off_q_o,
  input  logic [AW:0]   wr_cnt_i,
  input  logic [AW:0]   rd_cnt_i,
  input  logic          retx_i,
  output logic          almost_empty_n_o,
  output logic          almost_full_n_o
);
  prog_mode_e    mode;
  logic          serial_mode;
  logic [AW-1:0] off_empty;
  logic [AW-1:0] off_full;
  logic          rd_sel;
  logic          any_rst;
  logic          empty_hit;
  logic          full_hit;

  assign any_rst     = mst_rst_i | part_rst_i;
  assign serial_mode = (mode == PROG_SERIAL);

  afo_offset_bank #(.AW(AW), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)) u_bank (
    .wclk_i      (wclk_i),
    .mst_rst_i   (mst_rst_i),
    .part_rst_i  (part_rst_i),
    .cfg_serial_i(cfg_serial_i),
    .prog_i      (prog_i),
    .wr_en_i     (wr_en_i),
    .ser_en_i    (ser_en_i),
    .ser_d_i     (ser_d_i),
    .off_d_i     (off_d_i),
    .mode_o      (mode),
    .off_empty_o (off_empty),
    .off_full_o  (off_full)
  );

  // readback selector, read-clock domain
  always_ff @(posedge rclk_i) begin
    if (any_rst)                rd_sel <= 1'b0;
    else if (prog_i && rd_en_i) rd_sel <= ~rd_sel;
  end

  assign off_q_o = rd_sel ? off_full : off_empty;

  afo_flag_cell #(.AW(AW), .FULL_SIDE(1'b0), .RST_VAL(1'b0)) u_empty_flag (
    .clk_i   (rclk_i),
    .rst_i   (any_rst),
    .hold_i  (retx_i),
    .cnt_i   (rd_cnt_i),
    .off_i   (off_empty),
    .hit_o   (empty_hit),
    .flag_n_o(almost_empty_n_o)
  );

  afo_flag_cell #(.AW(AW), .FULL_SIDE(1'b1), .RST_VAL(1'b1)) u_full_flag (
    .clk_i   (wclk_i),
    .rst_i   (any_rst),
    .hold_i  (1'b0),
    .cnt_i   (wr_cnt_i),
    .off_i   (off_full),
    .hit_o   (full_hit),
    .flag_n_o(almost_full_n_o)
  );

endmodule

// File: rtl/almost_flag_ctrl_chk.sv
module almost_flag_ctrl_chk #(
  parameter int AW      = 14,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          mst_rst_i,
  input logic          part_rst_i,
  input logic          cfg_serial_i,
  input logic          prog_i,
  input logic          wr_en_i,
  input logic          ser_en_i,
  input logic          retx_i,
  input logic [AW:0]   wr_cnt_i,
  input logic [AW:0]   rd_cnt_i,
  input logic          almost_empty_n_o,
  input logic          almost_full_n_o,
  input logic          serial_mode,
  input logic [AW-1:0] off_empty,
  input logic [AW-1:0] off_full
);
  localparam logic [AW:0]   DEPTH_V = {1'b1, {AW{1'b0}}};
  localparam logic [AW-1:0] DP      = AW'(DEF_PAR);
  localparam logic [AW-1:0] DS      = AW'(DEF_SER);

  p_defaults_r1: assert property (@(posedge wclk_i)
    mst_rst_i |=> (off_empty == ($past(cfg_serial_i) ? DS : DP)) &&
                  (off_full  == ($past(cfg_serial_i) ? DS : DP)) &&
                  (serial_mode == $past(cfg_serial_i)));

  p_mode_frozen_r2: assert property (@(posedge wclk_i) disable iff (mst_rst_i)
    1'b1 |=> $stable(serial_mode));

  p_serial_quiet_r2: assert property (@(posedge wclk_i) disable iff (mst_rst_i)
    (serial_mode && !ser_en_i) |=> ($stable(off_empty) && $stable(off_full)));

  p_parallel_quiet_r2: assert property (@(posedge wclk_i) disable iff (mst_rst_i)
    (!serial_mode && !(prog_i && wr_en_i)) |=> ($stable(off_empty) && $stable(off_full)));

  p_empty_flag_r7: assert property (@(posedge rclk_i) disable iff (mst_rst_i || part_rst_i)
    !retx_i |=> (almost_empty_n_o == !($past(rd_cnt_i) <= {1'b0, $past(off_empty)})));

  p_full_flag_r8: assert property (@(posedge wclk_i) disable iff (mst_rst_i || part_rst_i)
    1'b1 |=> (almost_full_n_o == !((DEPTH_V - $past(wr_cnt_i)) <= {1'b0, $past(off_full)})));

  p_retx_hold_r9: assert property (@(posedge rclk_i) disable iff (mst_rst_i || part_rst_i)
    retx_i |=> $stable(almost_empty_n_o));

  p_empty_rst_r10: assert property (@(posedge rclk_i)
    (mst_rst_i || part_rst_i) |=> !almost_empty_n_o);

  p_full_rst_r10: assert property (@(posedge wclk_i)
    (mst_rst_i || part_rst_i) |=> almost_full_n_o);

endmodule

bind almost_flag_ctrl almost_flag_ctrl_chk #(.AW(AW), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)) u_chk (.*);

// File: tb/almost_flag_ctrl_bench.sv
module almost_flag_ctrl_bench;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          mst_rst, part_rst, cfg_serial, prog, wr_en, rd_en, ser_en, ser_d, retx;
  logic [AW-1:0] off_d, off_q;
  logic [AW:0]   wr_cnt, rd_cnt;
  logic          ae_n, af_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  almost_flag_ctrl #(.AW(AW), .DEF_PAR(127), .DEF_SER(1023)) u_almost_flag_ctrl (
    .wclk_i(clk), .rclk_i(clk), .mst_rst_i(mst_rst), .part_rst_i(part_rst),
    .cfg_serial_i(cfg_serial), .prog_i(prog), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .ser_en_i(ser_en), .ser_d_i(ser_d), .off_d_i(off_d), .off_q_o(off_q),
    .wr_cnt_i(wr_cnt), .rd_cnt_i(rd_cnt), .retx_i(retx),
    .almost_empty_n_o(ae_n), .almost_full_n_o(af_n)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic read_pair(input string req, input int exp_e, input int exp_f);
    check(req, int'(off_q), exp_e);
    prog = 1'b1; rd_en = 1'b1;
    step();
    check(req, int'(off_q), exp_f);
    step();
    prog = 1'b0; rd_en = 1'b0;
  endtask

  task automatic par_write(input int e, input int f);
    prog = 1'b1; wr_en = 1'b1; off_d = AW'(e);
    step();
    off_d = AW'(f);
    step();
    prog = 1'b0; wr_en = 1'b0;
  endtask

  task automatic ser_write(input int e, input int f);
    logic [2*AW-1:0] stream;
    stream = {AW'(f), AW'(e)};
    ser_en = 1'b1;
    for (int i = 0; i < 2*AW; i++) begin
      ser_d = stream[i];
      step();
    end
    ser_en = 1'b0; ser_d = 1'b0;
  endtask

  task automatic do_reset(input logic serial);
    cfg_serial = serial; mst_rst = 1'b1;
    rd_cnt = AW+1'(DEPTH); wr_cnt = '0;
    step(); step();
    check("R10 empty flag in reset", int'(ae_n), 0);
    check("R10 full flag in reset", int'(af_n), 1);
    mst_rst = 1'b0;
    step();
  endtask

  task automatic sweep(input int e, input int f);
    for (int c = 0; c <= DEPTH; c++) begin
      rd_cnt = (AW+1)'(c); wr_cnt = (AW+1)'(c);
      step();
      check("R7 almost-empty sweep", int'(ae_n), (c <= e) ? 0 : 1);
      check("R8 almost-full sweep",  int'(af_n), ((DEPTH - c) <= f) ? 0 : 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    mst_rst = 1'b0; part_rst = 1'b0; cfg_serial = 1'b0; prog = 1'b0; wr_en = 1'b0;
    rd_en = 1'b0; ser_en = 1'b0; ser_d = 1'b0; retx = 1'b0; off_d = '0;
    wr_cnt = '0; rd_cnt = '0;
    @(negedge clk);

    // ---- parallel configuration
    do_reset(1'b0);
    read_pair("R1 R3 parallel defaults", 127, 127);
    ser_write(3, 4);
    read_pair("R2 serial ignored in parallel mode", 127, 127);
    par_write(5, 9);
    read_pair("R4 parallel write order", 5, 9);
    prog = 1'b1; wr_en = 1'b1; off_d = AW'(6);
    step();
    prog = 1'b0; wr_en = 1'b0;
    read_pair("R4 third write wraps to empty side", 6, 9);

    // R9 retransmit hold
    rd_cnt = (AW+1)'(100);
    step();
    check("R9 flag idle before setup", int'(ae_n), 1);
    rd_cnt = '0; retx = 1'b1;
    step();
    check("R9 held on setup edge", int'(ae_n), 1);
    retx = 1'b0;
    step();
    check("R9 updated on second edge", int'(ae_n), 0);

    // R6 partial reset: write pointer sits on full side now
    part_rst = 1'b1;
    step();
    check("R10 empty flag on partial reset", int'(ae_n), 0);
    check("R10 full flag on partial reset", int'(af_n), 1);
    part_rst = 1'b0;
    read_pair("R6 offsets kept after partial reset", 6, 9);
    par_write(40, 50);
    read_pair("R6 write sequence restarted", 40, 50);

    sweep(40, 50);
    par_write(0, 1023);
    read_pair("R4 extreme offsets", 0, 1023);
    sweep(0, 1023);

    // ---- serial configuration
    do_reset(1'b1);
    read_pair("R1 serial defaults", 1023, 1023);
    par_write(3, 4);
    read_pair("R2 parallel ignored in serial mode", 1023, 1023);
    ser_write(300, 700);
    read_pair("R5 serial load lsb first empty side first", 300, 700);
    sweep(300, 700);

    // partial shift, then partial reset restarts the bit sequence
    ser_en = 1'b1; ser_d = 1'b1;
    for (int i = 0; i < 5; i++) step();
    ser_en = 1'b0; ser_d = 1'b0;
    read_pair("R5 partial shift lands in empty side", 300 | 31, 700);
    part_rst = 1'b1;
    step();
    part_rst = 1'b0;
    ser_write(17, 900);
    read_pair("R6 serial sequence restarted, mode kept", 17, 900);
    par_write(1, 2);
    read_pair("R6 R2 still serial after partial reset", 17, 900);
    ser_write(1023, 0);
    sweep(1023, 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule